// File: doc/BRIEF.md
# Message-Object Interface Transfer Engine

This block sits inside a CAN controller between software and the message-object store. Software fills one of two interface register sets, picks in a command byte which field groups of an object take part and whether data flows into or out of the store, then writes an object number to start a transfer. The engine fetches the addressed object and merges only the chosen groups. It then either writes the merged object back or loads the chosen groups into the interface registers.

A read transfer can also clear the object's interrupt-pending and new-data flags in the store. A write transfer can raise the object's transmit request. The two interface sets are fully independent. When both start in the same cycle, set 1 is served first.

Top module: `cmo_xfer`

## Requirements
- R1: The command byte register (address 1) resets to zero, stores bits 7:0 of a write and reads bits 31:8 as zero. Bit 7 is direction (1 = into the store), 6 mask group, 5 arbitration group, 4 control group, 3 clear interrupt-pending, 2 clear new-data on a read or set transmit request on a write, 1 data word A, 0 data word B.
- R2: Writing an object number from 1 to NUM_OBJ into bits 5:0 of the request register (address 0) starts a transfer. The register reads the number in bits 5:0 and busy in bit 15. Busy reads 1 after the accepting edge and drops on the third rising edge after it when the transfer is uncontested. A number of 0 or above NUM_OBJ is ignored.
- R3: A read transfer (bit 7 = 0) loads only the selected groups into the interface registers. Unselected interface registers keep their values, and the stored object is unchanged apart from the flags of R5.
- R4: A write transfer stores only the selected groups into the object. Unselected groups keep their stored values, and the interface registers are unchanged.
- R5: A read transfer with bit 3 set clears the stored interrupt-pending flag, and one with bit 2 set clears the stored new-data flag. The interface registers receive the flag values from before the clear.
- R6: A write transfer with bit 2 set leaves the stored transmit request at 1, whatever the control group selection.
- R7: While a set is busy, every register write to that set is ignored.
- R8: The two interface sets keep separate registers. Traffic on one never changes the other's registers.
- R9: When both sets start in the same cycle, set 1 completes first. Set 2 stays busy until the sixth rising edge after the start.
- R10: Word layouts are as follows. Mask word (address 2): [28:0] identifier mask, [30] direction mask, [31] extended mask, bit 29 not stored. Arbitration word (address 3): [28:0] identifier, [29] direction, [30] extended, [31] valid. Control word (address 4): [15] new data, [13] interrupt pending, [12] use mask, [11] receive interrupt enable, [10] transmit interrupt enable, [8] transmit request, [7] end of buffer, [3:0] length. Data words A and B sit at addresses 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if1_we | input | 1 | Register write strobe, interface set 1 |
| if1_addr | input | 3 | Register address, set 1 |
| if1_wdata | input | 32 | Write data, set 1 |
| if1_rdata | output | 32 | Read data for if1_addr |
| if2_we | input | 1 | Register write strobe, interface set 2 |
| if2_addr | input | 3 | Register address, set 2 |
| if2_wdata | input | 32 | Write data, set 2 |
| if2_rdata | output | 32 | Read data for if2_addr |

## Verification
The bench writes an object through set 1 with a partial group selection and reads it back through set 2 under several other selections. An engine that merged whole objects would overwrite the unselected mask word or data word B. The read with both clear bits set is checked twice: once in the interface copy, which must still show the old flags, and once in a later read, which must show them cleared. Getting the order wrong loses the old values. Writes during busy, object numbers 0 and 33, and a same-cycle start on both sets are also driven. A wrong grant order or a missing busy guard shows up as the wrong busy pattern or a corrupted data word.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    localparam int IDW = 29;

    typedef enum logic [2:0] {
        RA_REQ  = 3'd0,
        RA_CMD  = 3'd1,
        RA_MSK  = 3'd2,
        RA_ARB  = 3'd3,
        RA_CTL  = 3'd4,
        RA_DA   = 3'd5,
        RA_DB   = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic           xtd_m;
        logic           dir_m;
        logic [IDW-1:0] id_m;
    } msk_t;

    typedef struct packed {
        logic           valid;
        logic           xtd;
        logic           dir;
        logic [IDW-1:0] id;
    } arb_t;

    typedef struct packed {
        logic       newdat;
        logic       intpnd;
        logic       umask;
        logic       rxie;
        logic       txie;
        logic       txrqst;
        logic       eob;
        logic [3:0] dlc;
    } ctl_t;

    typedef struct packed {
        msk_t        m;
        arb_t        a;
        ctl_t        c;
        logic [31:0] da;
        logic [31:0] db;
    } obj_t;

    // bit order 7..0 is the software-visible command byte layout
    typedef struct packed {
        logic wr;
        logic g_msk;
        logic g_arb;
        logic g_ctl;
        logic clr_int;
        logic nd_tx;
        logic g_da;
        logic g_db;
    } cmd_t;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_APPLY} seq_e;

    function automatic logic [31:0] msk_to_word(msk_t m);
        return {m.xtd_m, m.dir_m, 1'b0, m.id_m};
    endfunction

    function automatic msk_t word_to_msk(logic [31:0] w);
        msk_t m;
        logic unused_b29;
        unused_b29 = w[29];
        m.xtd_m = w[31];
        m.dir_m = w[30];
        m.id_m  = w[IDW-1:0];
        return m;
    endfunction

    function automatic logic [31:0] ctl_to_word(ctl_t c);
        logic [31:0] w;
        w       = '0;
        w[15]   = c.newdat;
        w[13]   = c.intpnd;
        w[12]   = c.umask;
        w[11]   = c.rxie;
        w[10]   = c.txie;
        w[8]    = c.txrqst;
        w[7]    = c.eob;
        w[3:0]  = c.dlc;
        return w;
    endfunction

    function automatic ctl_t word_to_ctl(logic [31:0] w);
        ctl_t c;
        logic unused_bits;
        unused_bits = ^{w[31:16], w[14], w[9], w[6:4]};
        c.newdat = w[15];
        c.intpnd = w[13];
        c.umask  = w[12];
        c.rxie   = w[11];
        c.txie   = w[10];
        c.txrqst = w[8];
        c.eob    = w[7];
        c.dlc    = w[3:0];
        return c;
    endfunction

    // object content after a write transfer
    function automatic obj_t merge_into_obj(obj_t old, obj_t ifv, cmd_t cmd);
        obj_t o;
        o = old;
        if (cmd.g_msk) o.m  = ifv.m;
        if (cmd.g_arb) o.a  = ifv.a;
        if (cmd.g_ctl) o.c  = ifv.c;
        if (cmd.g_da)  o.da = ifv.da;
        if (cmd.g_db)  o.db = ifv.db;
        if (cmd.nd_tx) o.c.txrqst = 1'b1;
        return o;
    endfunction

    // interface content after a read transfer
    function automatic obj_t merge_into_if(obj_t ifv, obj_t obj, cmd_t cmd);
        obj_t o;
        o = ifv;
        if (cmd.g_msk) o.m  = obj.m;
        if (cmd.g_arb) o.a  = obj.a;
        if (cmd.g_ctl) o.c  = obj.c;
        if (cmd.g_da)  o.da = obj.da;
        if (cmd.g_db)  o.db = obj.db;
        return o;
    endfunction

    // object content after a read transfer with flag side effects
    function automatic obj_t clear_flags(obj_t obj, cmd_t cmd);
        obj_t o;
        o = obj;
        if (cmd.clr_int) o.c.intpnd = 1'b0;
        if (cmd.nd_tx)   o.c.newdat = 1'b0;
        return o;
    endfunction

endpackage

// File: rtl/cmo_objram.sv
module cmo_objram
    import cmo_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int AW      = $clog2(NUM_OBJ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_idx_i,
    output obj_t          rd_obj_o,
    input  logic          we_i,
    input  logic [AW-1:0] wr_idx_i,
    input  obj_t          wr_obj_i
);

    obj_t mem [NUM_OBJ];
    obj_t rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_OBJ; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            if (we_i) mem[wr_idx_i] <= wr_obj_i;
            rd_q <= mem[rd_idx_i];
        end
    end

    assign rd_obj_o = rd_q;

endmodule

// File: rtl/cmo_seq.sv
module cmo_seq
    import cmo_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int AW      = $clog2(NUM_OBJ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i   [2],
    input  logic [AW-1:0] idx_i   [2],
    input  cmd_t          cmd_i   [2],
    input  obj_t          regs_i  [2],
    output logic          done_o  [2],
    output obj_t          ld_obj_o,
    output logic [AW-1:0] ram_rd_idx_o,
    input  obj_t          ram_rd_obj_i,
    output logic          ram_we_o,
    output logic [AW-1:0] ram_wr_idx_o,
    output obj_t          ram_wr_obj_o
);

    seq_e          st_q;
    logic          cur_q;
    logic [AW-1:0] cur_idx_q;
    cmd_t          cur_cmd;
    obj_t          cur_if;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            cur_q     <= 1'b0;
            cur_idx_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (req_i[0]) begin
                        cur_q     <= 1'b0;
                        cur_idx_q <= idx_i[0];
                        st_q      <= S_FETCH;
                    end else if (req_i[1]) begin
                        cur_q     <= 1'b1;
                        cur_idx_q <= idx_i[1];
                        st_q      <= S_FETCH;
                    end
                end
                S_FETCH: st_q <= S_APPLY;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cur_cmd      = cmd_i[cur_q];
        cur_if       = regs_i[cur_q];
        done_o[0]    = (st_q == S_APPLY) && !cur_q;
        done_o[1]    = (st_q == S_APPLY) &&  cur_q;
        ram_rd_idx_o = cur_idx_q;
        ram_wr_idx_o = cur_idx_q;
        ram_we_o     = (st_q == S_APPLY) && (cur_cmd.wr || cur_cmd.clr_int || cur_cmd.nd_tx);
        ram_wr_obj_o = cur_cmd.wr ? merge_into_obj(ram_rd_obj_i, cur_if, cur_cmd)
                                  : clear_flags(ram_rd_obj_i, cur_cmd);
        ld_obj_o     = merge_into_if(cur_if, ram_rd_obj_i, cur_cmd);
    end

    assert_fetch_then_apply_R2: assert property (@(posedge clk) disable iff (rst)
        st_q == S_FETCH |=> st_q == S_APPLY);

    assert_set1_first_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && req_i[0] && req_i[1]) |=> (st_q == S_FETCH && !cur_q));

    assert_read_keeps_fields_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_APPLY && !cur_cmd.wr) |->
            (ram_wr_obj_o.m == ram_rd_obj_i.m && ram_wr_obj_o.a == ram_rd_obj_i.a &&
             ram_wr_obj_o.da == ram_rd_obj_i.da && ram_wr_obj_o.db == ram_rd_obj_i.db));

    assert_read_clears_int_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_APPLY && !cur_cmd.wr && cur_cmd.clr_int) |-> (ram_we_o && !ram_wr_obj_o.c.intpnd));

    assert_write_sets_tx_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_APPLY && cur_cmd.wr && cur_cmd.nd_tx) |-> (ram_we_o && ram_wr_obj_o.c.txrqst));

    assert_write_keeps_db_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_APPLY && cur_cmd.wr && !cur_cmd.g_db) |-> ram_wr_obj_o.db == ram_rd_obj_i.db);

endmodule

// File: rtl/cmo_ifset.sv
module cmo_ifset
    import cmo_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int AW      = $clog2(NUM_OBJ),
    parameter int MNW     = $clog2(NUM_OBJ + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [2:0]    addr_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o,
    output logic          req_o,
    output logic [AW-1:0] idx_o,
    output cmd_t          cmd_o,
    output obj_t          regs_o,
    input  logic          done_i,
    input  obj_t          ld_obj_i
);

    localparam logic [MNW-1:0] MAX_NUM = MNW'(NUM_OBJ);
    localparam logic [MNW-1:0] ONE_NUM = MNW'(1);

    cmd_t           cmd_q;
    obj_t           regs_q;
    logic [MNW-1:0] num_q;
    logic [AW-1:0]  idx_q;
    logic           busy_q;
    logic [MNW-1:0] wnum;
    logic           num_ok;

    assign wnum   = wdata_i[MNW-1:0];
    assign num_ok = (wnum != '0) && (wnum <= MAX_NUM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            regs_q <= '0;
            num_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (done_i) begin
            busy_q <= 1'b0;
            if (!cmd_q.wr) regs_q <= ld_obj_i;
        end else if (we_i && !busy_q) begin
            unique case (reg_addr_e'(addr_i))
                RA_REQ: if (num_ok) begin
                    num_q  <= wnum;
                    idx_q  <= AW'(wnum - ONE_NUM);
                    busy_q <= 1'b1;
                end
                RA_CMD:  cmd_q     <= cmd_t'(wdata_i[7:0]);
                RA_MSK:  regs_q.m  <= word_to_msk(wdata_i);
                RA_ARB:  regs_q.a  <= arb_t'(wdata_i);
                RA_CTL:  regs_q.c  <= word_to_ctl(wdata_i);
                RA_DA:   regs_q.da <= wdata_i;
                RA_DB:   regs_q.db <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (reg_addr_e'(addr_i))
            RA_REQ: begin
                rdata_o[15]      = busy_q;
                rdata_o[MNW-1:0] = num_q;
            end
            RA_CMD:  rdata_o[7:0] = cmd_q;
            RA_MSK:  rdata_o = msk_to_word(regs_q.m);
            RA_ARB:  rdata_o = regs_q.a;
            RA_CTL:  rdata_o = ctl_to_word(regs_q.c);
            RA_DA:   rdata_o = regs_q.da;
            RA_DB:   rdata_o = regs_q.db;
            default: rdata_o = '0;
        endcase
    end

    assign req_o  = busy_q;
    assign idx_o  = idx_q;
    assign cmd_o  = cmd_q;
    assign regs_o = regs_q;

    assert_done_only_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done_i |-> busy_q);

    assert_busy_locks_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> ($stable(cmd_q) && $stable(num_q)));

    assert_busy_locks_data_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_i) |=> $stable(regs_q));

    assert_write_keeps_if_R4: assert property (@(posedge clk) disable iff (rst)
        (done_i && cmd_q.wr) |=> $stable(regs_q));

endmodule

// File: rtl/cmo_xfer.sv
module cmo_xfer
    import cmo_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        if1_we,
    input  logic [2:0]  if1_addr,
    input  logic [31:0] if1_wdata,
    output logic [31:0] if1_rdata,
    input  logic        if2_we,
    input  logic [2:0]  if2_addr,
    input  logic [31:0] if2_wdata,
    output logic [31:0] if2_rdata
);

    localparam int AW  = $clog2(NUM_OBJ);
    localparam int MNW = $clog2(NUM_OBJ + 1);
    localparam int NS  = 2;

    logic          we_a    [NS];
    logic [2:0]    addr_a  [NS];
    logic [31:0]   wdata_a [NS];
    logic [31:0]   rdata_a [NS];
    logic          req_a   [NS];
    logic [AW-1:0] idx_a   [NS];
    cmd_t          cmd_a   [NS];
    obj_t          regs_a  [NS];
    logic          done_a  [NS];
    obj_t          ld_obj;

    logic [AW-1:0] ram_rd_idx;
    obj_t          ram_rd_obj;
    logic          ram_we;
    logic [AW-1:0] ram_wr_idx;
    obj_t          ram_wr_obj;

    assign we_a[0]    = if1_we;
    assign addr_a[0]  = if1_addr;
    assign wdata_a[0] = if1_wdata;
    assign we_a[1]    = if2_we;
    assign addr_a[1]  = if2_addr;
    assign wdata_a[1] = if2_wdata;
    assign if1_rdata  = rdata_a[0];
    assign if2_rdata  = rdata_a[1];

    for (genvar g = 0; g < NS; g++) begin : g_set
        cmo_ifset #(.NUM_OBJ(NUM_OBJ), .AW(AW), .MNW(MNW)) u_set (
            .clk      (clk),
            .rst      (rst),
            .we_i     (we_a[g]),
            .addr_i   (addr_a[g]),
            .wdata_i  (wdata_a[g]),
            .rdata_o  (rdata_a[g]),
            .req_o    (req_a[g]),
            .idx_o    (idx_a[g]),
            .cmd_o    (cmd_a[g]),
            .regs_o   (regs_a[g]),
            .done_i   (done_a[g]),
            .ld_obj_i (ld_obj)
        );
    end

    cmo_seq #(.NUM_OBJ(NUM_OBJ), .AW(AW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_a),
        .idx_i        (idx_a),
        .cmd_i        (cmd_a),
        .regs_i       (regs_a),
        .done_o       (done_a),
        .ld_obj_o     (ld_obj),
        .ram_rd_idx_o (ram_rd_idx),
        .ram_rd_obj_i (ram_rd_obj),
        .ram_we_o     (ram_we),
        .ram_wr_idx_o (ram_wr_idx),
        .ram_wr_obj_o (ram_wr_obj)
    );

    cmo_objram #(.NUM_OBJ(NUM_OBJ), .AW(AW)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_i (ram_rd_idx),
        .rd_obj_o (ram_rd_obj),
        .we_i     (ram_we),
        .wr_idx_i (ram_wr_idx),
        .wr_obj_i (ram_wr_obj)
    );

    assert_one_set_served_R9: assert property (@(posedge clk) disable iff (rst)
        !(done_a[0] && done_a[1]));

endmodule

// File: tb/cmo_xfer_tb_top.sv
module cmo_xfer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we1 = 1'b0, we2 = 1'b0;
    logic [2:0]  a1 = '0, a2 = '0;
    logic [31:0] d1 = '0, d2 = '0;
    logic [31:0] r1, r2;
    int          total = 0;
    int          bad   = 0;

    always #10 clk = ~clk;

    cmo_xfer #(.NUM_OBJ(32)) dut_i (
        .clk(clk), .rst(rst),
        .if1_we(we1), .if1_addr(a1), .if1_wdata(d1), .if1_rdata(r1),
        .if2_we(we2), .if2_addr(a2), .if2_wdata(d2), .if2_rdata(r2)
    );

    localparam logic [2:0] A_REQ = 3'd0, A_CMD = 3'd1, A_MSK = 3'd2, A_ARB = 3'd3,
                           A_CTL = 3'd4, A_DA = 3'd5, A_DB = 3'd6;
    localparam logic [1:0] K_W = 2'd0, K_T = 2'd1, K_C = 2'd2;
    localparam int NV = 32;

    // {kind, port, addr, requirement number, data}
    localparam logic [41:0] VECS [NV] = '{
        {K_W, 1'b0, A_MSK, 4'd4,  32'h8000_00FF},
        {K_W, 1'b0, A_ARB, 4'd4,  32'h8000_0123},
        {K_W, 1'b0, A_CTL, 4'd4,  32'h0000_A088},
        {K_W, 1'b0, A_DA,  4'd4,  32'h1122_3344},
        {K_W, 1'b0, A_DB,  4'd4,  32'h5566_7788},
        {K_W, 1'b0, A_CMD, 4'd4,  32'h0000_00F3},
        {K_T, 1'b0, A_REQ, 4'd4,  32'h0000_0005},
        // R3: read arbitration and data A only through set 2
        {K_W, 1'b1, A_CMD, 4'd3,  32'h0000_0022},
        {K_T, 1'b1, A_REQ, 4'd3,  32'h0000_0005},
        {K_C, 1'b1, A_ARB, 4'd3,  32'h8000_0123},
        {K_C, 1'b1, A_DA,  4'd3,  32'h1122_3344},
        {K_C, 1'b1, A_DB,  4'd3,  32'h0000_0000},
        {K_C, 1'b1, A_MSK, 4'd3,  32'h0000_0000},
        // R5: read control with both clears, then again
        {K_W, 1'b1, A_CMD, 4'd5,  32'h0000_001C},
        {K_T, 1'b1, A_REQ, 4'd5,  32'h0000_0005},
        {K_C, 1'b1, A_CTL, 4'd5,  32'h0000_A088},
        {K_W, 1'b1, A_CMD, 4'd5,  32'h0000_0010},
        {K_T, 1'b1, A_REQ, 4'd5,  32'h0000_0005},
        {K_C, 1'b1, A_CTL, 4'd5,  32'h0000_0088},
        // R4 and R6: partial write with transmit request
        {K_W, 1'b0, A_MSK, 4'd4,  32'h0000_0000},
        {K_W, 1'b0, A_DA,  4'd4,  32'hDEAD_BEEF},
        {K_W, 1'b0, A_CMD, 4'd6,  32'h0000_0086},
        {K_T, 1'b0, A_REQ, 4'd6,  32'h0000_0005},
        {K_W, 1'b1, A_CMD, 4'd4,  32'h0000_0053},
        {K_T, 1'b1, A_REQ, 4'd4,  32'h0000_0005},
        {K_C, 1'b1, A_MSK, 4'd4,  32'h8000_00FF},
        {K_C, 1'b1, A_DA,  4'd4,  32'hDEAD_BEEF},
        {K_C, 1'b1, A_DB,  4'd4,  32'h5566_7788},
        {K_C, 1'b1, A_CTL, 4'd6,  32'h0000_0188},
        // R8: the sets keep separate command bytes and registers
        {K_C, 1'b0, A_CMD, 4'd8,  32'h0000_0086},
        {K_C, 1'b1, A_ARB, 4'd8,  32'h8000_0123},
        // R1: upper command bits are not stored
        {K_W, 1'b0, A_CMD, 4'd1,  32'hFFFF_FF86}
    };

    task automatic wr(input int p, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        if (p == 0) begin we1 = 1'b1; a1 = a; d1 = d; end
        else        begin we2 = 1'b1; a2 = a; d2 = d; end
        @(negedge clk);
        we1 = 1'b0;
        we2 = 1'b0;
    endtask

    task automatic wr_both(input logic [2:0] a, input logic [31:0] da, input logic [31:0] db);
        @(negedge clk);
        we1 = 1'b1; a1 = a; d1 = da;
        we2 = 1'b1; a2 = a; d2 = db;
        @(negedge clk);
        we1 = 1'b0;
        we2 = 1'b0;
    endtask

    task automatic chk(input int p, input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] got;
        if (p == 0) a1 = a; else a2 = a;
        #1;
        got = (p == 0) ? r1 : r2;
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s set%0d addr%0d got=%h exp=%h", tag, p + 1, a, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2 / R10: reset state
        chk(0, A_CMD, 32'h0, "R1");
        chk(0, A_REQ, 32'h0, "R2");
        chk(1, A_CTL, 32'h0, "R10");

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VECS[i];
            case (v[41:40])
                K_W: wr(int'(v[39]), v[38:36], v[31:0]);
                K_T: begin
                    wr(int'(v[39]), v[38:36], v[31:0]);
                    repeat (3) @(negedge clk);
                end
                default: begin
                    @(negedge clk);
                    chk(int'(v[39]), v[38:36], v[31:0], $sformatf("R%0d", v[35:32]));
                end
            endcase
        end
        @(negedge clk);
        chk(0, A_CMD, 32'h0000_0086, "R1");

        // R10: bit 29 of the mask word is not stored
        wr(1, A_MSK, 32'h2000_0001);
        chk(1, A_MSK, 32'h0000_0001, "R10");

        // R2: busy timing of an uncontested transfer
        wr(0, A_REQ, 32'd5);
        chk(0, A_REQ, 32'h0000_8005, "R2");
        @(negedge clk);
        @(negedge clk);
        chk(0, A_REQ, 32'h0000_8005, "R2");
        @(negedge clk);
        chk(0, A_REQ, 32'h0000_0005, "R2");

        // R2: numbers 0 and 33 are ignored
        wr(0, A_REQ, 32'd0);
        chk(0, A_REQ, 32'h0000_0005, "R2");
        wr(0, A_REQ, 32'd33);
        chk(0, A_REQ, 32'h0000_0005, "R2");

        // R7: write during busy is ignored
        wr(0, A_CMD, 32'h80);
        wr(0, A_REQ, 32'd7);
        wr(0, A_DA, 32'h0BAD_F00D);
        @(negedge clk);
        chk(0, A_DA, 32'hDEAD_BEEF, "R7");
        chk(0, A_REQ, 32'h0000_0007, "R7");

        // R9: both sets start in the same cycle
        wr(1, A_CMD, 32'h53);
        wr_both(A_REQ, 32'd9, 32'd9);
        chk(0, A_REQ, 32'h0000_8009, "R9");
        chk(1, A_REQ, 32'h0000_8009, "R9");
        repeat (3) @(negedge clk);
        chk(0, A_REQ, 32'h0000_0009, "R9");
        chk(1, A_REQ, 32'h0000_8009, "R9");
        repeat (2) @(negedge clk);
        chk(1, A_REQ, 32'h0000_8009, "R9");
        @(negedge clk);
        chk(1, A_REQ, 32'h0000_0009, "R9");
        chk(1, A_DA, 32'h0000_0000, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule